// File: doc/BRIEF.md
# Four-Phase Vertical Shift Clock Generator

This block sequences the four overlapping shift clocks that step charge one row at a time through the image and storage arrays of an area sensor. Time is cut into slots of a programmable length. Eight slots make one row period. A start strobe launches a job of a programmed number of rows. The job begins and ends with a slot of quiet margin. A one-cycle done pulse closes it.

Two modes are supported. In transfer mode the image clocks copy the storage clocks slot for slot, so a whole frame moves into storage. In readout mode, which also serves for cleaning passes and paired-row binning shifts, only the storage clocks move. The image clocks then hold their rest levels while the image area integrates. Row count, slot length and mode are captured when a job is accepted and hold for its whole length.

Top module: `vclk_gen`

## Requirements
- R1: While reset is asserted, and afterwards while idle, both phase buses hold the rest pattern (bits 2 and 3 high, bits 0 and 1 low) and `donePulse` is low.
- R2: One slot lasts `slotDiv`+1 clock cycles, and one row lasts eight slots.
- R3: In slot s (0 to 7 within a row), phase bit n is high exactly when (s - 2n) mod 8 is below 5. So each phase is high for 5 slots and low for 3, and each slot change flips exactly one phase bit.
- R4: A start is sampled on a rising edge (edge 0) while idle. The outputs keep the rest pattern for one slot (T = `slotDiv`+1 cycles). The first row slot appears after edge T+1.
- R5: A job drives exactly `rowCount` rows (8·`rowCount` slots, up to 1044 and beyond), then keeps the rest pattern for one more slot.
- R6: `donePulse` is high for exactly one cycle, after edge 2T+8·`rowCount`·T+1, with both buses at rest.
- R7: With `xferMode`=1, `imgPhase` equals `memPhase` in every cycle of the job.
- R8: With `xferMode`=0, `imgPhase` stays at the rest pattern while `memPhase` runs the row pattern.
- R9: A start with `rowCount`=0 is ignored: no phase moves and no done pulse follows.
- R10: A start, or any change of `rowCount`, `slotDiv` or `xferMode`, during a job has no effect on that job's outputs.
- R11: A start presented in the cycle where `donePulse` is high is accepted and begins a new job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Launch a job when idle |
| rowCount | input | ROW_W | Number of rows to shift |
| xferMode | input | 1 | 1: image follows storage; 0: storage only |
| slotDiv | input | DIV_W | Slot length minus one, in clock cycles |
| imgPhase | output | 4 | Image-area shift clocks, bit n = phase n |
| memPhase | output | 4 | Storage-area shift clocks, bit n = phase n |
| donePulse | output | 1 | One-cycle end-of-job strobe |

## Verification
A slot counter stepping at the wrong time shows within one slot as a phase edge that is missing, extra or misplaced on `memPhase`. Every slot boundary is compared cycle by cycle. A row counter that is off by one moves the done pulse by a full eight-slot row, and the trailing rest margin is then misplaced. A captured setting that leaks a mid-job input change alters the slot length or image bus within T cycles. A wrong mode latch shows on `imgPhase` in the first row slot.

// File: rtl/vclk_pkg.sv
package vclk_pkg;
  localparam int NUM_PH     = 4;
  localparam int SLOTS      = 8;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int STAGGER    = SLOTS / NUM_PH;
  localparam int HIGH_SLOTS = 5;

  typedef struct packed {
    logic load;   // slot index to zero, row pattern starts next
    logic step;   // advance to the next slot
    logic run;    // row pattern on the storage bus
    logic xfer;   // image bus follows storage bus
    logic done;   // end of job
  } vclkStrobe_t;
endpackage

// File: rtl/vclk_ctrl.sv
module vclk_ctrl
  import vclk_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [ROW_W-1:0] rowCount,
  input  logic             xferMode,
  input  logic [DIV_W-1:0] slotDiv,
  output vclkStrobe_t      strb
);
  localparam int LEFT_W = ROW_W + SLOT_W;

  typedef enum logic [2:0] {ST_IDLE, ST_LEAD, ST_RUN, ST_TRAIL, ST_DONE} ctrlState_t;

  ctrlState_t        state;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  divLim;
  logic [LEFT_W-1:0] slotsLeft;
  logic              xferQ;
  logic              tick;

  assign tick = (divCnt == divLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      divLim    <= '0;
      slotsLeft <= '0;
      xferQ     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startPulse && (rowCount != '0)) begin
            state     <= ST_LEAD;
            divCnt    <= '0;
            divLim    <= slotDiv;
            xferQ     <= xferMode;
            slotsLeft <= {rowCount, {SLOT_W{1'b0}}} - LEFT_W'(1);
          end
        end
        ST_LEAD: begin
          if (tick) begin
            divCnt <= '0;
            state  <= ST_RUN;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_RUN: begin
          if (tick) begin
            divCnt <= '0;
            if (slotsLeft == '0) state <= ST_TRAIL;
            else slotsLeft <= slotsLeft - LEFT_W'(1);
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            divCnt <= '0;
            state  <= ST_DONE;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load = (state == ST_LEAD) && tick;
    strb.step = (state == ST_RUN) && tick;
    strb.run  = (state == ST_RUN);
    strb.xfer = xferQ;
    strb.done = (state == ST_DONE);
  end

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> ($stable(divLim) && $stable(xferQ)));

  // R9
  zero_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startPulse && rowCount == '0) |=> (state == ST_IDLE));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> (state == ST_IDLE));

  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= divLim);
endmodule

// File: rtl/vclk_phase_dp.sv
module vclk_phase_dp
  import vclk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  vclkStrobe_t       strb,
  output logic [NUM_PH-1:0] imgPhase,
  output logic [NUM_PH-1:0] memPhase,
  output logic              donePulse
);
  logic [SLOT_W-1:0] slot;
  logic [NUM_PH-1:0] slotPat;
  logic [NUM_PH-1:0] restPat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          slot <= '0;
    else if (strb.load) slot <= '0;
    else if (strb.step) slot <= slot + SLOT_W'(1);
  end

  for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
    localparam logic [SLOT_W-1:0] OFS = SLOT_W'(g * STAGGER);
    logic [SLOT_W-1:0] relSlot;
    logic [SLOT_W-1:0] relRest;
    assign relSlot    = slot - OFS;
    assign relRest    = SLOT_W'(SLOTS - 1) - OFS;
    assign slotPat[g] = (relSlot < SLOT_W'(HIGH_SLOTS));
    assign restPat[g] = (relRest < SLOT_W'(HIGH_SLOTS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memPhase  <= restPat;
      imgPhase  <= restPat;
      donePulse <= 1'b0;
    end else begin
      memPhase  <= strb.run ? slotPat : restPat;
      imgPhase  <= (strb.run && strb.xfer) ? slotPat : restPat;
      donePulse <= strb.done;
    end
  end

  // R3
  one_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(memPhase ^ $past(memPhase)) <= 1);

  // R3
  overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(memPhase) >= 2) && ($countones(memPhase) <= 3));

  // R7
  img_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (imgPhase != restPat) |-> (imgPhase == memPhase));

  // R6
  done_rest_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (memPhase == restPat && imgPhase == restPat));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
endmodule

// File: rtl/vclk_gen.sv
module vclk_gen
  import vclk_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [ROW_W-1:0] rowCount,
  input  logic             xferMode,
  input  logic [DIV_W-1:0] slotDiv,
  output logic [3:0]       imgPhase,
  output logic [3:0]       memPhase,
  output logic             donePulse
);
  vclkStrobe_t strb;

  vclk_ctrl #(.ROW_W(ROW_W), .DIV_W(DIV_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .rowCount   (rowCount),
    .xferMode   (xferMode),
    .slotDiv    (slotDiv),
    .strb       (strb)
  );

  vclk_phase_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .imgPhase  (imgPhase),
    .memPhase  (memPhase),
    .donePulse (donePulse)
  );
endmodule

// File: tb/vclk_gen_bench.sv
module vclk_gen_bench;
  localparam int ROW_W = 11;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startPulse = 1'b0;
  logic [ROW_W-1:0] rowCount = '0;
  logic             xferMode = 1'b0;
  logic [DIV_W-1:0] slotDiv = '0;
  logic [3:0]       imgPhase;
  logic [3:0]       memPhase;
  logic             donePulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit monOn  = 1'b0;

  typedef struct packed {
    logic [3:0] img;
    logic [3:0] mem;
    logic       done;
    logic [7:0] tag;
    logic [7:0] imgTag;
  } expItem_t;

  expItem_t expQ[$];

  vclk_gen #(.ROW_W(ROW_W), .DIV_W(DIV_W)) u_vclk_gen (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .rowCount(rowCount),
    .xferMode(xferMode), .slotDiv(slotDiv),
    .imgPhase(imgPhase), .memPhase(memPhase), .donePulse(donePulse)
  );

  always #10 clk = ~clk;

  function automatic logic [3:0] pat(input int s);
    logic [3:0] p;
    for (int n = 0; n < 4; n++) p[n] = ((((s - 2 * n) % 8) + 8) % 8) < 5;
    return p;
  endfunction

  function automatic string tagName(input int t);
    case (t)
      1:  return "R1";
      2:  return "R2";
      3:  return "R3";
      4:  return "R4";
      5:  return "R5";
      6:  return "R6";
      7:  return "R7";
      8:  return "R8";
      9:  return "R9";
      10: return "R10";
      11: return "R11";
      default: return "R?";
    endcase
  endfunction

  function automatic expItem_t mk(input logic [3:0] i, input logic [3:0] m,
                                  input logic d, input int t, input int it);
    expItem_t e;
    e.img = i; e.mem = m; e.done = d; e.tag = 8'(t); e.imgTag = 8'(it);
    return e;
  endfunction

  // monitor: pops expected items and compares the outputs
  always begin
    @(posedge clk);
    #5;
    if (monOn) begin
      expItem_t e;
      if (expQ.size() > 0) e = expQ.pop_front();
      else e = mk(pat(7), pat(7), 1'b0, 9, 9);   // idle: R9 and R1
      checks++;
      if (memPhase !== e.mem) begin
        errors++;
        $display("FAIL %s memPhase actual %b expected %b", tagName(int'(e.tag)), memPhase, e.mem);
      end
      if (imgPhase !== e.img) begin
        errors++;
        $display("FAIL %s imgPhase actual %b expected %b", tagName(int'(e.imgTag)), imgPhase, e.img);
      end
      if (donePulse !== e.done) begin
        errors++;
        $display("FAIL %s donePulse actual %b expected %b", tagName(int'(e.tag)), donePulse, e.done);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // driver: called at a falling edge, pushes the expected output stream
  task automatic runJob(input int rows, input int div, input bit mode,
                        input int leadTag, input bit perturb);
    int t = div + 1;
    int d = 2 * t + 8 * rows * t;
    logic [3:0] rest = pat(7);
    startPulse = 1'b1;
    rowCount   = ROW_W'(rows);
    slotDiv    = DIV_W'(div);
    xferMode   = mode;
    expQ.push_back(mk(rest, rest, 1'b0, leadTag, leadTag));
    for (int j = 1; j <= d + 1; j++) begin
      int c = j - 1;
      if (c < t) begin
        expQ.push_back(mk(rest, rest, 1'b0, leadTag, leadTag));       // R4 lead margin
      end else if (c < t + 8 * rows * t) begin
        int s = ((c - t) / t) % 8;
        int mt = (((c - t) % t) == 0) ? 2 : 3;                        // R2 slot edge, R3 body
        int it = mode ? 7 : 8;                                        // R7 / R8
        expQ.push_back(mk(mode ? pat(s) : rest, pat(s), 1'b0, mt, it));
      end else if (c < d) begin
        expQ.push_back(mk(rest, rest, 1'b0, 5, 5));                   // R5 trailing margin
      end else begin
        expQ.push_back(mk(rest, rest, 1'b1, 6, 6));                   // R6 done
      end
    end
    @(negedge clk);
    startPulse = 1'b0;
    if (perturb) begin
      // R10: restart attempt and new settings during the job
      repeat (3 * t + 2) @(negedge clk);
      startPulse = 1'b1;
      rowCount   = ROW_W'(2);
      slotDiv    = '0;
      xferMode   = ~mode;
      @(negedge clk);
      startPulse = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (memPhase !== 4'b1100 || imgPhase !== 4'b1100 || donePulse !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual mem %b img %b done %b expected 1100 1100 0",
               memPhase, imgPhase, donePulse);
    end
    rstN  = 1'b1;
    monOn = 1'b1;
    repeat (3) @(negedge clk);

    runJob(3, 0, 1'b1, 4, 1'b0);       // transfer, shortest slot
    repeat (2) @(negedge clk);
    runJob(2, 3, 1'b0, 4, 1'b0);       // readout, four-cycle slot
    repeat (2) @(negedge clk);
    runJob(1044, 0, 1'b1, 5, 1'b0);    // R5 full frame transfer
    repeat (2) @(negedge clk);

    // R9: zero rows ignored
    startPulse = 1'b1;
    rowCount   = '0;
    xferMode   = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    repeat (12) @(negedge clk);

    runJob(2, 2, 1'b1, 10, 1'b1);      // R10 perturbed mid-job
    repeat (2) @(negedge clk);

    runJob(1, 1, 1'b1, 4, 1'b0);       // R11 back-to-back
    runJob(1, 0, 1'b0, 11, 1'b0);
    repeat (6) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule